// File: doc/BRIEF.md
# Second Operand Shifter Generator

This combinational unit builds the 32-bit second operand of a data-processing instruction from its 12-bit operand field. It also builds the shifter carry-out that the flag logic uses. It handles three layouts. In the first, an 8-bit constant is rotated right by twice a 4-bit count. In the second, a register value is shifted by a 5-bit constant. In the third, a register value is shifted by the low byte of a second register.

The decode stage supplies the operand field, the immediate-select bit, the value read for the shifted register, the value read for the amount register and the current carry flag. Register reads, the ALU, condition checks and flag writeback sit outside this block. The carry-out is always driven, because a separate instruction bit decides later whether it is written to the flags.

Top module: `operand_shifter`

## Requirements
- R1: With `imm_sel`=1, `operand` is `field[7:0]` zero-extended to 32 bits and rotated right by 2×`field[11:8]`.
- R2: With `imm_sel`=1, `carry_out` is `operand[31]` when `field[11:8]` is nonzero, and `carry_in` when it is zero.
- R3: Shift type is `field[6:5]`: 00 logical left, 01 logical right, 10 arithmetic right, 11 rotate right. With `imm_sel`=0 and `field[4]`=0, a logical left shift by constant amount `field[11:7]` equal to 0 passes `rm_val` through and keeps `carry_in`.
- R4: In the constant form (`field[4]`=0), logical right or arithmetic right with amount 0 acts as a shift by 32. Logical right then gives 0 with carry `rm_val[31]`. Arithmetic right then gives all sign bits with carry `rm_val[31]`.
- R5: In the constant form, rotate right with amount 0 gives `{carry_in, rm_val[31:1]}` with carry `rm_val[0]`.
- R6: In the register form (`field[4]`=1), only `rs_val[7:0]` is the amount. When that amount is 0, `rm_val` passes through and `carry_in` is kept for every shift type.
- R7: In the register form, logical left or logical right by exactly 32 gives 0, with carry `rm_val[0]` for left and `rm_val[31]` for right. Amounts above 32 give 0 with carry 0.
- R8: In the register form, arithmetic right by 32 or more fills `operand` with `rm_val[31]`, and `carry_out` is `rm_val[31]`.
- R9: In the register form, rotate right by a nonzero amount rotates by the amount modulo 32, and `carry_out` is `operand[31]`. A nonzero multiple of 32 therefore returns `rm_val` with carry `rm_val[31]`.
- R10: For shift amounts 1 to 31 in either register layout, `operand` is the shifted `rm_val`, and `carry_out` is the last bit shifted out.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| field | input | 12 | Second-operand field of the instruction |
| imm_sel | input | 1 | 1 selects the rotated-constant layout |
| rm_val | input | 32 | Value of the register to be shifted |
| rs_val | input | 32 | Value of the register holding a shift amount |
| carry_in | input | 1 | Current carry flag |
| operand | output | 32 | Generated second operand |
| carry_out | output | 1 | Shifter carry-out |

## Verification
The bench targets the places where amounts are reinterpreted. These are a constant amount of 0 for the right shifts and the rotate, a register amount of exactly 32 versus 33 and above, and register amounts whose upper bytes are set but whose low byte is 0. A design that ignored the shift-by-32 rule would pass `rm_val` through unchanged for a constant right shift of 0. A design without the one-bit rotate through carry would lose `carry_in` from bit 31. A design that used all 32 bits of `rs_val` would zero the result where it should pass through. On the immediate side, a carry taken from bit 31 with a rotate count of 0, or a rotate by the count instead of twice the count, shows up at once against the bit-by-bit reference.

// File: rtl/operand_shifter.sv
module operand_shifter (
  input  logic [11:0] field,
  input  logic        imm_sel,
  input  logic [31:0] rm_val,
  input  logic [31:0] rs_val,
  input  logic        carry_in,
  output logic [31:0] operand,
  output logic        carry_out
);
  localparam logic [1:0] SH_LSL = 2'b00;
  localparam logic [1:0] SH_LSR = 2'b01;
  localparam logic [1:0] SH_ASR = 2'b10;
  localparam logic [1:0] SH_ROR = 2'b11;

  wire [3:0]  rot     = field[11:8];
  wire [7:0]  imm8    = field[7:0];
  wire [1:0]  sh      = field[6:5];
  wire        by_reg  = field[4];
  wire [63:0] imm_dbl = {24'b0, imm8, 24'b0, imm8} >> {rot, 1'b0};

  logic [7:0]  n;
  logic [32:0] t;
  logic [63:0] d;

  always_comb begin
    n = by_reg ? rs_val[7:0] : {3'b0, field[11:7]};
    t = '0;
    d = '0;
    operand   = rm_val;
    carry_out = carry_in;
    if (imm_sel) begin
      operand   = imm_dbl[31:0];
      carry_out = (rot != 4'd0) ? imm_dbl[31] : carry_in;
    end else if (!by_reg && n == 8'd0 && sh == SH_ROR) begin
      operand   = {carry_in, rm_val[31:1]};
      carry_out = rm_val[0];
    end else begin
      if (!by_reg && n == 8'd0 && sh != SH_LSL) n = 8'd32;
      if (n != 8'd0) begin
        unique case (sh)
          SH_LSL: begin
            if (n < 8'd33) begin
              t = {1'b0, rm_val} << n;
              operand   = t[31:0];
              carry_out = t[32];
            end else begin
              operand   = '0;
              carry_out = 1'b0;
            end
          end
          SH_LSR: begin
            if (n < 8'd33) begin
              t = {rm_val, 1'b0} >> n;
              operand   = t[32:1];
              carry_out = t[0];
            end else begin
              operand   = '0;
              carry_out = 1'b0;
            end
          end
          SH_ASR: begin
            if (n < 8'd32) begin
              t = 33'($signed({rm_val, 1'b0}) >>> n);
              operand   = t[32:1];
              carry_out = t[0];
            end else begin
              operand   = {32{rm_val[31]}};
              carry_out = rm_val[31];
            end
          end
          default: begin
            d = {rm_val, rm_val} >> n[4:0];
            operand   = d[31:0];
            carry_out = d[31];
          end
        endcase
      end
    end
  end

  always_comb begin
    if (imm_sel && rot == 4'd0)
      p_imm_norot_r2: assert (operand == {24'b0, imm8} && carry_out == carry_in);
    if (imm_sel)
      p_imm_bits_r1: assert ($countones(operand) == $countones(imm8));
    if (!imm_sel && by_reg && rs_val[7:0] == 8'd0)
      p_reg_zero_pass_r6: assert (operand == rm_val && carry_out == carry_in);
    if (!imm_sel && by_reg && rs_val[7:0] > 8'd32 && !sh[1])
      p_reg_big_zero_r7: assert (operand == 32'd0 && !carry_out);
    if (!imm_sel && by_reg && rs_val[7:0] >= 8'd32 && sh == SH_ASR)
      p_reg_big_sign_r8: assert (operand == {32{rm_val[31]}} && carry_out == rm_val[31]);
    if (!imm_sel && by_reg && rs_val[7:0] != 8'd0 && sh == SH_ROR)
      p_reg_rot_bits_r9: assert ($countones(operand) == $countones(rm_val) && carry_out == operand[31]);
    if (!imm_sel && !by_reg && field[11:7] == 5'd0 && sh == SH_ROR)
      p_rrx_r5: assert (operand[31] == carry_in && carry_out == rm_val[0]);
  end
endmodule

// File: tb/operand_shifter_bench.sv
module operand_shifter_bench;
  logic clk = 0;
  always #10 clk = ~clk;
  logic rst = 1;

  logic [11:0] field;
  logic        imm_sel;
  logic [31:0] rm_val, rs_val, operand;
  logic        carry_in, carry_out;

  int checks = 0, errors = 0, cycles = 0;

  operand_shifter u_operand_shifter (
    .field(field), .imm_sel(imm_sel), .rm_val(rm_val), .rs_val(rs_val),
    .carry_in(carry_in), .operand(operand), .carry_out(carry_out)
  );

  always @(posedge clk) begin
    cycles <= cycles + 1;
    if (cycles > 150000) begin
      errors = errors + 1;
      $display("FAIL watchdog: actual %0d cycles expected < 150000", cycles);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  task automatic model(input logic [11:0] f, input logic is, input logic [31:0] rm,
                       input logic [31:0] rs, input logic ci,
                       output logic [31:0] v, output logic c, output string tag);
    int amt;
    logic [1:0] ty;
    ty = f[6:5];
    c = ci;
    if (is) begin
      v = {24'b0, f[7:0]};
      for (int i = 0; i < 2 * int'(f[11:8]); i++) v = {v[0], v[31:1]};
      if (f[11:8] != 0) c = v[31];
      tag = (f[11:8] == 0) ? "R2" : "R1";
      return;
    end
    v = rm;
    if (!f[4]) begin
      amt = int'(f[11:7]);
      if (amt == 0) begin
        if (ty == 2'b00) begin tag = "R3"; return; end
        if (ty == 2'b11) begin v = {ci, rm[31:1]}; c = rm[0]; tag = "R5"; return; end
        amt = 32; tag = "R4";
      end else tag = (ty == 2'b00) ? "R3" : "R10";
    end else begin
      amt = int'(rs[7:0]);
      if (amt == 0) tag = "R6";
      else if (amt >= 32) tag = (ty == 2'b10) ? "R8" : (ty == 2'b11) ? "R9" : "R7";
      else tag = "R10";
    end
    for (int i = 0; i < amt; i++) begin
      case (ty)
        2'b00: begin c = v[31]; v = v << 1; end
        2'b01: begin c = v[0]; v = v >> 1; end
        2'b10: begin c = v[0]; v = {v[31], v[31:1]}; end
        default: begin v = {v[0], v[31:1]}; c = v[31]; end
      endcase
    end
  endtask

  task automatic apply(input logic [11:0] f, input logic is, input logic [31:0] rm,
                       input logic [31:0] rs, input logic ci);
    logic [31:0] ev; logic ec; string tag;
    @(posedge clk);
    field = f; imm_sel = is; rm_val = rm; rs_val = rs; carry_in = ci;
    @(negedge clk);
    model(f, is, rm, rs, ci, ev, ec, tag);
    checks++;
    if (operand !== ev || carry_out !== ec) begin
      errors++;
      $display("FAIL %s: field=%h imm=%b rm=%h rs=%h cin=%b actual %h/%b expected %h/%b",
               tag, f, is, rm, rs, ci, operand, carry_out, ev, ec);
    end
  endtask

  initial begin
    field = 0; imm_sel = 0; rm_val = 0; rs_val = 0; carry_in = 0;
    repeat (3) @(posedge clk);
    rst = 0;
    @(negedge clk);
    checks++;
    if (operand !== 0 || carry_out !== 0) begin
      errors++;
      $display("FAIL R3 idle: actual %h/%b expected 0/0", operand, carry_out);
    end
    // R1/R2: every rotate count
    for (int r = 0; r < 16; r++) begin
      apply({r[3:0], 8'hA5}, 1, 32'h0, 32'h0, 1'b1);
      apply({r[3:0], 8'h81}, 1, 32'h0, 32'h0, 1'b0);
    end
    // R3/R4/R5/R10: constant form, every type and amount
    for (int ty = 0; ty < 4; ty++)
      for (int a = 0; a < 32; a++) begin
        apply({a[4:0], ty[1:0], 1'b0, 4'h3}, 0, 32'h8000_0001, 32'hFFFF_FFFF, 1'b1);
        apply({a[4:0], ty[1:0], 1'b0, 4'h3}, 0, 32'h7F00_FF02, 32'h0, 1'b0);
      end
    // R6/R7/R8/R9/R10: register form, amounts 0..40 and big ones
    for (int ty = 0; ty < 4; ty++) begin
      for (int a = 0; a < 41; a++) begin
        apply({4'h5, 1'b0, ty[1:0], 1'b1, 4'h2}, 0, 32'hC000_0003, {24'hABCDEF, a[7:0]}, 1'b1);
        apply({4'h5, 1'b0, ty[1:0], 1'b1, 4'h2}, 0, 32'h4000_0002, {24'h0, a[7:0]}, 1'b0);
      end
      apply({4'h1, 1'b0, ty[1:0], 1'b1, 4'h0}, 0, 32'hDEAD_BEEF, 32'hFFFF_FF00, 1'b1);
      apply({4'h1, 1'b0, ty[1:0], 1'b1, 4'h0}, 0, 32'hDEAD_BEEF, 32'h0000_0040, 1'b0);
      apply({4'h1, 1'b0, ty[1:0], 1'b1, 4'h0}, 0, 32'h8765_4321, 32'h0000_00FF, 1'b1);
    end
    // random patterns across all layouts
    for (int k = 0; k < 3000; k++) begin
      logic [31:0] rs;
      rs = $urandom;
      if (k % 2 == 0) rs[7:0] = rs[7:0] % 8'd48;
      apply(12'($urandom), 1'($urandom), $urandom, rs, 1'($urandom));
    end
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule